// File: doc/BRIEF.md
# Warp Shared-Memory Bank Conflict Serializer

This block sits in front of a banked scratchpad. It receives one request for a whole warp, made of a word address and an active flag for each thread, and splits that request into a sequence of conflict-free rounds. In each round every bank is given at most one address. The block also reports which threads are served by that round. Threads that reach the same bank with the same word address are served together as a broadcast. Threads that reach the same bank with different addresses are spread over successive cycles.

The bank of a word is the low bits of its word address, so consecutive words sit in consecutive banks. At the moment a request is accepted, the block works out the conflict degree: the largest number of distinct active addresses that fall on any single bank. The request then takes exactly that many rounds, or one round when no thread is active. The degree is presented alongside every round, and the last round is flagged as done. Conflicts are only counted among the threads of one request. A new request is taken only after the previous one has finished.

Top module: `smc_serializer`

## Requirements
- R1: The bank of a thread is its word address modulo NUM_BANKS (the low log2(NUM_BANKS) address bits; 32 banks by default). In every round, each thread that is granted has its bank enabled, and that bank's round address equals the thread's address.
- R2: A request whose active threads all fall on different banks completes in a single round with degree 1. Unit stride and a reversed permutation are examples.
- R3: The number of rounds equals the conflict degree, which is the maximum number of distinct active addresses on one bank. Stride 2 gives 2, stride 8 gives 8 and stride 32 gives 32.
- R4: All active threads that share one word address are granted in the same round (broadcast).
- R5: In each round, a bank's address is the address of the lowest-numbered active thread of that bank that has not yet been served. Every unserved thread with that address is granted in that round.
- R6: Inactive threads are never granted and do not add to the degree. A request with no active thread takes one round with an empty grant, no bank enabled, and degree 0.
- R7: req_ready is high only when the block is idle. It falls in the cycle after a request is accepted and rises again in the cycle after the done round. A req_valid seen while req_ready is low has no effect.
- R8: The first round is presented in the cycle after acceptance, and rounds follow in consecutive cycles. rnd_done is high in the last round only. rnd_degree holds the request's degree in every round.
- R9: After reset, req_ready is 1 and rnd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when req_ready is high |
| req_active | input | NUM_THREADS | Per-thread active flag |
| req_addr | input | NUM_THREADS*ADDR_W | Per-thread word address; thread t occupies bits t*ADDR_W upward |
| req_ready | output | 1 | Idle and able to accept a request |
| rnd_valid | output | 1 | A round is being presented |
| rnd_bank_en | output | NUM_BANKS | Bank is accessed in this round |
| rnd_bank_addr | output | NUM_BANKS*ADDR_W | Per-bank word address for this round |
| rnd_grant | output | NUM_THREADS | Threads served by this round |
| rnd_done | output | 1 | This round is the last of the request |
| rnd_degree | output | $clog2(NUM_THREADS+1) | Conflict degree of the request in service |

## Verification
On every cycle, the assertions check the following. Each granted thread matches the enabled address of its bank. Grants only go to threads that are still pending. Every round makes progress. The count of rounds at done agrees with the degree. req_ready and rnd_valid are never high together, and the degree stays fixed during a request. Other properties need a reference that is independent of the design, and only the bench's scenarios can show them. These are the degree values for particular strides, broadcasts and mixed patterns. They also include the lowest-thread-first order of addresses within a bank, and the fact that a request arriving while busy has no effect.

// File: rtl/smc_pkg.sv
package smc_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } smc_state_e;
endpackage

// File: rtl/smc_degree.sv
module smc_degree #(
    parameter int NUM_THREADS = 32,
    parameter int NUM_BANKS   = 32,
    parameter int ADDR_W      = 10,
    parameter int DEG_W       = 6
) (
    input  logic [NUM_THREADS-1:0]        active,
    input  logic [NUM_THREADS*ADDR_W-1:0] addr,
    output logic [DEG_W-1:0]              degree
);
    localparam int BANK_W = $clog2(NUM_BANKS);

    logic [NUM_THREADS-1:0] first_of_addr;
    logic [DEG_W-1:0]       bank_cnt [NUM_BANKS];

    // A thread counts once per distinct address: only when no lower active
    // thread carries the same word address.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_first
        logic is_first;
        always_comb begin
            is_first = active[t];
            for (int u = 0; u < t; u++) begin
                if (active[u] && addr[u*ADDR_W +: ADDR_W] == addr[t*ADDR_W +: ADDR_W])
                    is_first = 1'b0;
            end
        end
        assign first_of_addr[t] = is_first;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cnt
        logic [DEG_W-1:0] cnt;
        always_comb begin
            cnt = '0;
            for (int t = 0; t < NUM_THREADS; t++) begin
                if (first_of_addr[t] && addr[t*ADDR_W +: BANK_W] == BANK_W'(b))
                    cnt = cnt + DEG_W'(1);
            end
        end
        assign bank_cnt[b] = cnt;
    end

    always_comb begin
        degree = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_cnt[b] > degree)
                degree = bank_cnt[b];
        end
    end
endmodule

// File: rtl/smc_bank_pick.sv
module smc_bank_pick #(
    parameter int NUM_THREADS = 32,
    parameter int NUM_BANKS   = 32,
    parameter int ADDR_W      = 10
) (
    input  logic [NUM_THREADS-1:0]        pend,
    input  logic [NUM_THREADS*ADDR_W-1:0] addr,
    output logic [NUM_BANKS-1:0]          bank_en,
    output logic [NUM_BANKS*ADDR_W-1:0]   bank_addr
);
    localparam int BANK_W = $clog2(NUM_BANKS);

    // Per bank: the lowest pending thread leads and sets this round's address.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic              en;
        logic [ADDR_W-1:0] lead_addr;
        always_comb begin
            en        = 1'b0;
            lead_addr = '0;
            for (int t = NUM_THREADS - 1; t >= 0; t--) begin
                if (pend[t] && addr[t*ADDR_W +: BANK_W] == BANK_W'(b)) begin
                    en        = 1'b1;
                    lead_addr = addr[t*ADDR_W +: ADDR_W];
                end
            end
        end
        assign bank_en[b]                    = en;
        assign bank_addr[b*ADDR_W +: ADDR_W] = lead_addr;
    end
endmodule

// File: rtl/smc_grant.sv
module smc_grant #(
    parameter int NUM_THREADS = 32,
    parameter int NUM_BANKS   = 32,
    parameter int ADDR_W      = 10
) (
    input  logic [NUM_THREADS-1:0]        pend,
    input  logic [NUM_THREADS*ADDR_W-1:0] addr,
    input  logic [NUM_BANKS-1:0]          bank_en,
    input  logic [NUM_BANKS*ADDR_W-1:0]   bank_addr,
    output logic [NUM_THREADS-1:0]        grant
);
    localparam int BANK_W = $clog2(NUM_BANKS);

    // A pending thread is served when its bank's chosen address is its own,
    // which also covers broadcast among equal addresses.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic [BANK_W-1:0] bk;
        assign bk       = addr[t*ADDR_W +: BANK_W];
        assign grant[t] = pend[t] && bank_en[bk]
                          && (bank_addr[int'(bk)*ADDR_W +: ADDR_W] == addr[t*ADDR_W +: ADDR_W]);
    end
endmodule

// File: rtl/smc_serializer.sv
module smc_serializer
    import smc_pkg::*;
#(
    parameter int NUM_THREADS = 32,
    parameter int NUM_BANKS   = 32,
    parameter int ADDR_W      = 10
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    input  logic [NUM_THREADS-1:0]                 req_active,
    input  logic [NUM_THREADS*ADDR_W-1:0]          req_addr,
    output logic                                   req_ready,
    output logic                                   rnd_valid,
    output logic [NUM_BANKS-1:0]                   rnd_bank_en,
    output logic [NUM_BANKS*ADDR_W-1:0]            rnd_bank_addr,
    output logic [NUM_THREADS-1:0]                 rnd_grant,
    output logic                                   rnd_done,
    output logic [$clog2(NUM_THREADS+1)-1:0]       rnd_degree
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int DEG_W  = $clog2(NUM_THREADS + 1);

    typedef struct packed {
        smc_state_e                    state;
        logic [NUM_THREADS-1:0]        pend;
        logic [NUM_THREADS*ADDR_W-1:0] addr;
        logic [DEG_W-1:0]              degree;
        logic [DEG_W-1:0]              rounds;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [DEG_W-1:0]              deg_in;
    logic [NUM_BANKS-1:0]          bank_en;
    logic [NUM_BANKS*ADDR_W-1:0]   bank_addr;
    logic [NUM_THREADS-1:0]        grant;
    logic                          serving;
    logic                          last_round;

    smc_degree #(
        .NUM_THREADS(NUM_THREADS), .NUM_BANKS(NUM_BANKS),
        .ADDR_W(ADDR_W), .DEG_W(DEG_W)
    ) u_degree (
        .active (req_active),
        .addr   (req_addr),
        .degree (deg_in)
    );

    smc_bank_pick #(
        .NUM_THREADS(NUM_THREADS), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
    ) u_pick (
        .pend      (regs_q.pend),
        .addr      (regs_q.addr),
        .bank_en   (bank_en),
        .bank_addr (bank_addr)
    );

    smc_grant #(
        .NUM_THREADS(NUM_THREADS), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
    ) u_grant (
        .pend      (regs_q.pend),
        .addr      (regs_q.addr),
        .bank_en   (bank_en),
        .bank_addr (bank_addr),
        .grant     (grant)
    );

    assign serving    = (regs_q.state == ST_SERVE);
    assign last_round = serving && ((regs_q.pend & ~grant) == '0);

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    regs_d.state  = ST_SERVE;
                    regs_d.pend   = req_active;
                    regs_d.addr   = req_addr;
                    regs_d.degree = deg_in;
                    regs_d.rounds = '0;
                end
            end
            ST_SERVE: begin
                regs_d.pend   = regs_q.pend & ~grant;
                regs_d.rounds = regs_q.rounds + DEG_W'(1);
                if (last_round)
                    regs_d.state = ST_IDLE;
            end
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign req_ready     = (regs_q.state == ST_IDLE);
    assign rnd_valid     = serving;
    assign rnd_bank_en   = bank_en;
    assign rnd_bank_addr = bank_addr;
    assign rnd_grant     = grant;
    assign rnd_done      = last_round;
    assign rnd_degree    = regs_q.degree;

    // ------------------------------------------------------------ assertions
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
        logic [BANK_W-1:0] cbk;
        assign cbk = regs_q.addr[t*ADDR_W +: BANK_W];
        AST_GRANT_BANK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            rnd_grant[t] |-> (rnd_bank_en[cbk]
                && rnd_bank_addr[int'(cbk)*ADDR_W +: ADDR_W] == regs_q.addr[t*ADDR_W +: ADDR_W])); // R1
    end

    AST_GRANT_PENDING_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_valid |-> ((rnd_grant & ~regs_q.pend) == '0)); // R6

    AST_ROUND_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_valid && regs_q.pend != '0) |-> (rnd_grant != '0)); // R8

    AST_ROUNDS_MATCH_DEGREE: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_done |-> ((regs_q.degree == '0) ? (regs_q.rounds == '0)
                                            : (regs_q.rounds + DEG_W'(1) == regs_q.degree))); // R3

    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rnd_valid); // R7

    AST_DEGREE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_valid && !rnd_done) |=> (rnd_valid && $stable(rnd_degree))); // R8

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_done |=> req_ready); // R7
endmodule

// File: tb/smc_serializer_tb.sv
module smc_serializer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int T  = 32;
    localparam int B  = 32;
    localparam int AW = 10;
    localparam int DW = $clog2(T + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [T-1:0]      req_active = '0;
    logic [T*AW-1:0]   req_addr = '0;
    logic              req_ready;
    logic              rnd_valid;
    logic [B-1:0]      rnd_bank_en;
    logic [B*AW-1:0]   rnd_bank_addr;
    logic [T-1:0]      rnd_grant;
    logic              rnd_done;
    logic [DW-1:0]     rnd_degree;

    int n_chk = 0;
    int n_fail = 0;

    int act_m  [T];
    int addr_m [T];
    int list_m [B][T];
    int len_m  [B];
    int exp_deg;
    int exp_rounds;

    always #(CLK_PERIOD/2) clk = ~clk;

    smc_serializer #(.NUM_THREADS(T), .NUM_BANKS(B), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_active(req_active),
        .req_addr(req_addr), .req_ready(req_ready), .rnd_valid(rnd_valid),
        .rnd_bank_en(rnd_bank_en), .rnd_bank_addr(rnd_bank_addr), .rnd_grant(rnd_grant),
        .rnd_done(rnd_done), .rnd_degree(rnd_degree)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: per bank, distinct addresses in order of first thread.
    task automatic build_model();
        exp_deg = 0;
        for (int b = 0; b < B; b++) len_m[b] = 0;
        for (int t = 0; t < T; t++) begin
            if (act_m[t] != 0) begin
                int b;
                bit seen;
                b = addr_m[t] % B;
                seen = 0;
                for (int k = 0; k < len_m[b]; k++)
                    if (list_m[b][k] == addr_m[t]) seen = 1;
                if (!seen) begin
                    list_m[b][len_m[b]] = addr_m[t];
                    len_m[b]++;
                end
            end
        end
        for (int b = 0; b < B; b++) if (len_m[b] > exp_deg) exp_deg = len_m[b];
        exp_rounds = (exp_deg == 0) ? 1 : exp_deg;
    endtask

    task automatic run_req(string tag, bit junk_while_busy);
        build_model();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        for (int t = 0; t < T; t++) begin
            req_active[t] = (act_m[t] != 0);
            req_addr[t*AW +: AW] = AW'(addr_m[t]);
        end
        @(negedge clk);
        if (junk_while_busy) begin
            req_active = '1;
            for (int t = 0; t < T; t++) req_addr[t*AW +: AW] = AW'(t * 32);
        end else begin
            req_valid = 1'b0;
        end
        for (int r = 0; r < exp_rounds; r++) begin
            logic [T-1:0] eg;
            logic [B-1:0] een;
            int bad_addr;
            eg = '0;
            een = '0;
            bad_addr = 0;
            for (int b = 0; b < B; b++) begin
                een[b] = (r < len_m[b]);
                if (een[b] && rnd_bank_addr[b*AW +: AW] != AW'(list_m[b][r])) bad_addr++;
            end
            for (int t = 0; t < T; t++)
                if (act_m[t] != 0 && r < len_m[addr_m[t] % B]
                    && addr_m[t] == list_m[addr_m[t] % B][r]) eg[t] = 1'b1;
            chk("R8", {tag, " round valid"}, longint'(rnd_valid), 1);
            chk("R7", {tag, " ready low while busy"}, longint'(req_ready), 0);
            chk("R3", {tag, " degree"}, longint'(rnd_degree), longint'(exp_deg));
            chk("R1", {tag, " bank enables"}, longint'(rnd_bank_en), longint'(een));
            chk("R5", {tag, " bank address mismatches"}, longint'(bad_addr), 0);
            chk("R4", {tag, " grant"}, longint'(rnd_grant), longint'(eg));
            chk("R8", {tag, " done flag"}, longint'(rnd_done), longint'(r == exp_rounds - 1));
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R7", {tag, " idle after done (valid)"}, longint'(rnd_valid), 0);
        chk("R7", {tag, " idle after done (ready)"}, longint'(req_ready), 1);
    endtask

    task automatic fill(int mode);
        for (int t = 0; t < T; t++) begin
            act_m[t] = 1;
            case (mode)
                0: addr_m[t] = t + 100;
                1: addr_m[t] = 64 + (T - 1 - t);
                2: addr_m[t] = 2 * t;
                3: addr_m[t] = 8 * t;
                4: addr_m[t] = 32 * t;
                5: addr_m[t] = 5;
                6: addr_m[t] = ((t * 3) % 4) * 32 + 3;
                7: begin
                    act_m[t]  = (t % 2 == 0) ? 1 : 0;
                    addr_m[t] = (t % 2 == 0) ? t : 32 * t + (t - 1);
                end
                default: begin
                    act_m[t]  = 0;
                    addr_m[t] = 32 * t;
                end
            endcase
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lfsr;
        repeat (3) @(negedge clk);
        chk("R9", "reset ready", longint'(req_ready), 1);
        chk("R9", "reset round valid", longint'(rnd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "ready after reset release", longint'(req_ready), 1);

        fill(0); run_req("R2 unit stride", 0);
        fill(1); run_req("R2 reversed permutation", 0);
        fill(2); run_req("R3 stride 2", 0);
        fill(3); run_req("R3 stride 8", 0);
        fill(4); run_req("R3 stride 32", 0);
        fill(5); run_req("R4 full broadcast", 0);
        fill(6); run_req("R5 mixed broadcast order", 0);
        fill(7); run_req("R6 inactive conflicts", 0);
        fill(8); run_req("R6 no active thread", 0);
        fill(2); run_req("R7 request while busy", 1);
        fill(0); run_req("R7 back to back", 0);

        lfsr = 32'h1ACE;
        for (int n = 0; n < 24; n++) begin
            for (int t = 0; t < T; t++) begin
                lfsr = (lfsr << 1) ^ (((lfsr >>> 31) & 1) != 0 ? 32'h04C11DB7 : 0);
                act_m[t]  = ((lfsr >> 7) % 5 != 0) ? 1 : 0;
                addr_m[t] = (lfsr >> 3) & ((n % 2 == 0) ? 127 : 1023);
            end
            run_req("R5 random pattern", 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule